// File: doc/BRIEF.md
# External Bus Cycle Timing Controller

This block runs one external memory access at a time: an instruction fetch, a data read or a data write. Each access starts with an address latch enable pulse and then drives exactly one active-low strobe. A fetch uses the program-store strobe, a read uses the read strobe and a write uses the write strobe. The controller runs at the oscillator rate, so one clock cycle is one oscillator period.

The address latch enable pulse is one period long by default. An active-low extend input stretches it to three periods so that a slow external latch can capture the address. The strobe is one period long plus a number of wait states. The wait-state count comes from one of two 2-bit configuration fields, and the field is chosen by the region byte (the upper 8 bits of a 24-bit address). Both fields use an inverted code, so an all-ones field means no wait states.

Requests use a valid/ready handshake. The requester raises `req_valid` and holds the kind and region stable until a clock edge where `req_ready` is high. A request is taken on that edge. Nothing is queued: while a cycle is running `req_ready` stays low and the request waits, which is the block's back-pressure. The configuration pins are plain control inputs. They are captured on the accepting edge and are not looked at again until the next accepted request.

Top module: `ebus_cycle_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it: `ale` = 0, `rd_n` = `wr_n` = `psen_n` = 1, `busy` = 0, `done` = 0.
- R2: When `cfg_ale_ext_n` is 1 at acceptance, `ale` is high for exactly 1 cycle. When it is 0, `ale` is high for exactly 3 cycles. `ale` rises in the cycle after the accepting edge.
- R3: The active strobe is low for 1 + W cycles. W is the selected wait field inverted: code 2'b00 gives W=3, 2'b01 gives W=2, 2'b10 gives W=1 and 2'b11 gives W=0.
- R4: A region byte equal to 8'h01 selects `cfg_wsb`. Every other region value selects `cfg_wsa`, including 8'h00, 8'hFE, 8'hFF and all unlisted values.
- R5: `req_kind` selects the strobe: 2'b00 fetch drives `psen_n`, 2'b01 read drives `rd_n`, 2'b10 write drives `wr_n`, and the reserved code 2'b11 acts as a read. At most one strobe is low at any time.
- R6: The strobe goes low in the cycle right after `ale` falls. `ale` and any strobe are never active in the same cycle.
- R7: `done` is high for exactly one cycle, in the cycle right after the strobe returns high. `busy` is high from the cycle after acceptance through the `done` cycle, a total of ALE length + strobe length + 1 cycles, and is low in the next cycle.
- R8: `req_ready` is the inverse of `busy`. A request is taken only on an edge where `req_valid` and `req_ready` are both high. A request held while `busy` is high starts no extra cycle and does not change the running one.
- R9: The kind, region and configuration inputs are sampled only at acceptance. Changing them during a cycle has no effect on that cycle's timing or strobe.
- R10: Whenever `busy` is low, `ale` is 0 and all three strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 read |
| req_region | input | 8 | Upper address byte selecting the wait field |
| cfg_ale_ext_n | input | 1 | Active-low ALE stretch select |
| cfg_wsa | input | 2 | Inverted wait code for the default regions |
| cfg_wsb | input | 2 | Inverted wait code for region 8'h01 |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program-store (fetch) strobe, active low |
| busy | output | 1 | An access cycle is in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit region, 2-bit wait fields, and ALE lengths of 1 and 3. With these defaults every wait code and both ALE lengths can be reached, giving strobe widths from 1 to 4 and busy windows from 3 to 8 cycles. The stimulus covers region 01 against 00, FE, FF and an unlisted region, so both wait fields are checked against each other. Other requests exercise the reserved kind code, a request held during back-pressure, and configuration changes in the middle of a cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ALE,
    PH_STRB,
    PH_DONE
  } bus_phase_e;

  // Strobe lane numbering used by the output stage.
  localparam int LANE_PSEN = 0;
  localparam int LANE_RD   = 1;
  localparam int LANE_WR   = 2;
  localparam int NUM_LANES = 3;

  function automatic int lane_of(input acc_kind_e k);
    case (k)
      K_FETCH: return LANE_PSEN;
      K_WRITE: return LANE_WR;
      default: return LANE_RD;
    endcase
  endfunction

endpackage

// File: rtl/ebc_cfg_sel.sv
module ebc_cfg_sel #(
  parameter int REGION_W = 8,
  parameter int WS_W = 2,
  parameter logic [REGION_W-1:0] REGION_ALT = 8'h01,
  parameter int ALE_SHORT = 1,
  parameter int ALE_LONG = 3,
  parameter int CNT_W = 3
) (
  input  logic [REGION_W-1:0] region,
  input  logic                ale_ext_n,
  input  logic [WS_W-1:0]     ws_main,
  input  logic [WS_W-1:0]     ws_alt,
  output logic [CNT_W-1:0]    ale_len,
  output logic [CNT_W-1:0]    wait_cnt,
  output logic                ale_long
);

  logic [WS_W-1:0] field;

  always_comb begin
    field    = (region == REGION_ALT) ? ws_alt : ws_main;
    wait_cnt = {{(CNT_W-WS_W){1'b0}}, ~field};
    ale_long = ~ale_ext_n;
    ale_len  = ale_long ? CNT_W'(ALE_LONG) : CNT_W'(ALE_SHORT);
  end

endmodule

// File: rtl/ebc_cfg_hold.sv
module ebc_cfg_hold
  import ebc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  acc_kind_e        kind_d,
  input  logic [CNT_W-1:0] wait_d,
  input  logic             long_d,
  output acc_kind_e        kind_q,
  output logic [CNT_W-1:0] wait_q,
  output logic             long_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_READ;
      wait_q <= '0;
      long_q <= 1'b0;
    end else if (accept) begin
      kind_q <= kind_d;
      wait_q <= wait_d;
      long_q <= long_d;
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(kind_q) && $stable(wait_q) && $stable(long_q)));

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] ale_len_d,
  input  logic [CNT_W-1:0] wait_q,
  output bus_phase_e       phase,
  output logic             accept,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  assign busy   = (phase != PH_IDLE);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_ALE;
          cnt   <= ale_len_d - 1'b1;
        end
        PH_ALE: if (cnt == '0) begin
          phase <= PH_STRB;
          cnt   <= wait_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_STRB: if (cnt == '0) begin
          phase <= PH_DONE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_start_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_done_returns_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> !busy);

endmodule

// File: rtl/ebc_strobe_out.sv
module ebc_strobe_out
  import ebc_pkg::*;
(
  input  bus_phase_e phase,
  input  acc_kind_e  kind_q,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       psen_n,
  output logic       done
);

  logic [NUM_LANES-1:0] lane_n;
  int                   sel;

  assign sel = lane_of(kind_q);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_n[i] = !((phase == PH_STRB) && (sel == i));
  end

  assign ale    = (phase == PH_ALE);
  assign done   = (phase == PH_DONE);
  assign psen_n = lane_n[LANE_PSEN];
  assign rd_n   = lane_n[LANE_RD];
  assign wr_n   = lane_n[LANE_WR];

  always_comb begin
    assert_single_strobe_R5: assert ($countones(~lane_n) <= 1);
  end

endmodule

// File: rtl/ebus_cycle_ctrl.sv
module ebus_cycle_ctrl
  import ebc_pkg::*;
#(
  parameter int REGION_W = 8,
  parameter int WS_W = 2,
  parameter logic [REGION_W-1:0] REGION_ALT = 8'h01,
  parameter int ALE_SHORT = 1,
  parameter int ALE_LONG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [REGION_W-1:0] req_region,
  input  logic                cfg_ale_ext_n,
  input  logic [WS_W-1:0]     cfg_wsa,
  input  logic [WS_W-1:0]     cfg_wsb,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic                psen_n,
  output logic                busy,
  output logic                done
);

  localparam int MAX_WS  = (1 << WS_W) - 1;
  localparam int MAX_LEN = (ALE_LONG > MAX_WS) ? ALE_LONG : MAX_WS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;

  logic [CNT_W-1:0] ale_len_d, wait_d, wait_q;
  logic             long_d, long_q, accept;
  acc_kind_e        kind_q;
  bus_phase_e       phase;

  ebc_cfg_sel #(
    .REGION_W(REGION_W), .WS_W(WS_W), .REGION_ALT(REGION_ALT),
    .ALE_SHORT(ALE_SHORT), .ALE_LONG(ALE_LONG), .CNT_W(CNT_W)
  ) u_sel (
    .region(req_region), .ale_ext_n(cfg_ale_ext_n),
    .ws_main(cfg_wsa), .ws_alt(cfg_wsb),
    .ale_len(ale_len_d), .wait_cnt(wait_d), .ale_long(long_d)
  );

  ebc_cfg_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .kind_d(acc_kind_e'(req_kind)), .wait_d(wait_d), .long_d(long_d),
    .kind_q(kind_q), .wait_q(wait_q), .long_q(long_q)
  );

  ebc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .ale_len_d(ale_len_d), .wait_q(wait_q),
    .phase(phase), .accept(accept), .busy(busy)
  );

  ebc_strobe_out u_out (
    .phase(phase), .kind_q(kind_q),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .done(done)
  );

  assign req_ready = !busy;

  logic strobe_on;
  assign strobe_on = !(rd_n && wr_n && psen_n);

  assert_ale_excl_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && strobe_on));

  assert_strobe_follows_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(ale));

  assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(strobe_on) && !strobe_on));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && !strobe_on && !done));

  assert_ale_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && long_q) |-> ($past(ale, 2) && $past(ale, 3)));

  assert_ale_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && !long_q) |-> !$past(ale, 2));

endmodule

// File: tb/ebus_cycle_ctrl_test.sv
module ebus_cycle_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  typedef struct {
    logic [2:0] lanes;   // {psen, rd, wr} active mask
    int         ale_len;
    int         str_len;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_region = 8'h00;
  logic       cfg_ale_ext_n = 1'b1;
  logic [1:0] cfg_wsa = 2'b11;
  logic [1:0] cfg_wsb = 2'b11;
  logic       req_ready, ale, rd_n, wr_n, psen_n, busy, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  exp_t sb[$];

  ebus_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_region(req_region), .cfg_ale_ext_n(cfg_ale_ext_n),
    .cfg_wsa(cfg_wsa), .cfg_wsb(cfg_wsb), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .psen_n(psen_n), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Monitor: measures each cycle and compares with the scoreboard.
  int         ale_c = 0, str_c = 0, busy_c = 0;
  bit         prev_low = 0, prev_ale = 0, start_ok = 1, overlap = 0, multi = 0;
  logic [2:0] seen = 3'b000;

  always @(negedge clk) begin
    logic [2:0] lows;
    lows = {~psen_n, ~rd_n, ~wr_n};
    if (rst_n) begin
      if (busy) busy_c++;
      if (ale) ale_c++;
      if (ale && (|lows)) overlap = 1;
      if ($countones(lows) > 1) multi = 1;
      if (|lows) begin
        if (!prev_low && !prev_ale) start_ok = 0;
        str_c++;
        seen |= lows;
      end
      if (done) begin
        if (sb.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(ale_c == e.ale_len, "R2 ale width", ale_c, e.ale_len);
          check(str_c == e.str_len, "R3/R4 strobe width", str_c, e.str_len);
          check(seen == e.lanes, "R5 strobe select", seen, e.lanes);
          check(!multi, "R5 single strobe", multi, 0);
          check(start_ok && !overlap, "R6 strobe after ale", overlap, 0);
          check(prev_low && lows == 3'b000, "R7 done timing", prev_low, 1);
          check(busy_c == e.ale_len + e.str_len + 1, "R7 busy length",
                busy_c, e.ale_len + e.str_len + 1);
        end
        ale_c = 0; str_c = 0; busy_c = 0; seen = 3'b000;
        start_ok = 1; overlap = 0; multi = 0;
      end
      prev_low = |lows;
      prev_ale = ale;
    end
  end

  function automatic logic [2:0] lane_mask(input logic [1:0] k);
    case (k)
      2'b00:   return 3'b100;
      2'b10:   return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  // Driver: presents one request, pushes its expectation, optionally
  // disturbs inputs during the cycle, and waits for the end of the cycle.
  task automatic run_req(input logic [1:0] k, input logic [7:0] reg_b,
                         input logic ext_n, input logic [1:0] wa,
                         input logic [1:0] wb, input bit disturb, input bit hold_busy);
    exp_t e;
    logic [1:0] f;
    @(negedge clk);
    req_kind = k; req_region = reg_b; cfg_ale_ext_n = ext_n;
    cfg_wsa = wa; cfg_wsb = wb; req_valid = 1'b1;
    f = (reg_b == 8'h01) ? wb : wa;
    e.lanes   = lane_mask(k);
    e.ale_len = ext_n ? 1 : 3;
    e.str_len = 1 + (3 - int'(f));
    sb.push_back(e);
    check(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    @(negedge clk);
    check(busy == 1'b1 && ale == 1'b1, "R2 ale rises after accept", ale, 1);
    check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
    if (hold_busy) begin
      req_kind = 2'b10; req_region = 8'h01; cfg_wsb = 2'b00; cfg_wsa = 2'b00;
      cfg_ale_ext_n = ~ext_n;
    end else begin
      req_valid = 1'b0;
    end
    if (disturb) begin
      req_kind = ~k; req_region = ~reg_b; cfg_ale_ext_n = ~ext_n;
      cfg_wsa = ~wa; cfg_wsb = ~wb;
    end
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7/R8 idle after done", busy, 0);
    check(ale == 1'b0 && {rd_n, wr_n, psen_n} == 3'b111, "R10 idle quiet",
          {ale, rd_n, wr_n, psen_n}, 4'b0111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ale == 1'b0 && {rd_n, wr_n, psen_n} == 3'b111 && !busy && !done,
          "R1 reset outputs", {ale, rd_n, wr_n, psen_n, busy, done}, 6'b011100);
    rst_n = 1'b1;
    @(negedge clk);
    check(ale == 1'b0 && {rd_n, wr_n, psen_n} == 3'b111 && !busy && !done,
          "R1 after reset", {ale, rd_n, wr_n, psen_n, busy, done}, 6'b011100);

    // R2 and R3: every wait code and both ALE widths, region 00 uses wsa (R4).
    for (int c = 0; c < 4; c++) begin
      run_req(2'b01, 8'h00, 1'b1, 2'(c), 2'b11, 0, 0);
      run_req(2'b00, 8'h00, 1'b0, 2'(c), 2'b11, 0, 0);
    end
    // R4: region 01 uses wsb; FE, FF and unlisted 5A use wsa.
    run_req(2'b10, 8'h01, 1'b1, 2'b11, 2'b00, 0, 0);
    run_req(2'b10, 8'h01, 1'b0, 2'b00, 2'b10, 0, 0);
    run_req(2'b01, 8'hFE, 1'b1, 2'b01, 2'b11, 0, 0);
    run_req(2'b00, 8'hFF, 1'b1, 2'b10, 2'b00, 0, 0);
    run_req(2'b01, 8'h5A, 1'b0, 2'b00, 2'b11, 0, 0);
    // R5: reserved kind acts as read.
    run_req(2'b11, 8'h00, 1'b1, 2'b10, 2'b11, 0, 0);
    // R9: inputs change mid-cycle.
    run_req(2'b00, 8'h01, 1'b1, 2'b11, 2'b01, 1, 0);
    run_req(2'b10, 8'hFE, 1'b0, 2'b10, 2'b00, 1, 0);
    // R8: request held during busy is not taken and does not alter the cycle.
    run_req(2'b01, 8'h00, 1'b1, 2'b11, 2'b11, 0, 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 no extra cycle", busy, 0);
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule